// File: doc/BRIEF.md
# Dual Tick Timer (One-Shot and Periodic)

This block holds two 32-bit tick timers built from one shared structure and reached through a small word-wide register port. One timer is a one-shot: once armed with an interval it counts tick-enable pulses down to zero, raises its expiry output for one clock and then disarms itself. The other is periodic: it raises its expiry output each time its interval runs out and restarts straight away from the stored interval.

Each timer has a control register, which holds the programmed interval and reads back the last value written, and a value register, which reports how many ticks remain. The tick rate is set outside the block by the `tick` enable input. Data on the bus is big-endian: the byte at the lowest address travels on the least significant lane of the data bus. Firmware arms a timer by writing a nonzero interval and stops it by writing zero.

Top module: `tick_timer_pair`

## Requirements
- R1: Register offsets are fixed: one-shot control 32, one-shot value 36, periodic control 40, periodic value 44. A legal read of any other offset returns 0. Writes to the value registers or to other offsets change nothing.
- R2: Bus data is big-endian. A register value V travels as {V[7:0], V[15:8], V[23:16], V[31:24]} on `wdata` and `rdata`, so bus bits [7:0] carry V[31:24].
- R3: Only accesses with `size` equal to 4 are legal. Any other size raises `err` in the same cycle, returns 0 on `rdata` and leaves every register unchanged.
- R4: A write of nonzero N to a control register arms that timer. Its expiry output goes high in the cycle after the Nth clock edge with `tick` high that follows the write edge. The control register then reads N.
- R5: A write of zero to a control register stops that timer. No expiry follows, and its value register reads 0.
- R6: Any write to a control register drops the count in progress and starts over from the newly written value.
- R7: A value register reads the ticks left before the next expiry. It decreases by one only on edges where `tick` is high, and reads 0 while its timer is stopped.
- R8: On expiry the one-shot pulses `cd_exp` for exactly one cycle. From then on both its control and value registers read 0 until it is written again.
- R9: On expiry the periodic timer pulses `pt_exp` and reloads its remaining count with the stored interval at that same edge. With an interval of 1 and `tick` held high, it pulses on every cycle.
- R10: When a control write and an expiry fall on the same clock edge, the write wins. That edge produces no expiry pulse.
- R11: After reset all four registers read 0 and neither expiry output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Tick enable; counts advance on edges where it is high |
| req | input | 1 | Bus access request for this cycle |
| we | input | 1 | 1 for write, 0 for read |
| addr | input | 6 | Byte offset of the register |
| size | input | 3 | Access size in bytes |
| wdata | input | 32 | Write data, big-endian lanes |
| rdata | output | 32 | Read data, big-endian lanes, valid in the request cycle |
| err | output | 1 | Access size error, valid in the request cycle |
| cd_exp | output | 1 | One-shot expiry pulse |
| pt_exp | output | 1 | Periodic expiry pulse |

## Verification
Two things can fall on the same clock edge: a control-register write and the tick that would make the timer expire. The bench causes this by writing the one-shot exactly one tick-edge after its count reaches 1, while `tick` is held high. It then expects no pulse, a freshly loaded count and the new interval on readback. A behavioural model in the bench tracks both timers edge by edge and is compared against both expiry outputs on every clock, so a collision that slips through on either timer shows up at once.

// File: rtl/tick_timer_pair.sv
module tick_timer_pair #(
  parameter int DW         = 32,
  parameter int AW         = 6,
  parameter int OFS_CD_CTL = 32,
  parameter int OFS_CD_VAL = 36,
  parameter int OFS_PT_CTL = 40,
  parameter int OFS_PT_VAL = 44
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    size,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic          cd_exp,
  output logic          pt_exp
);
  localparam int NB = DW / 8;

  logic          acc_ok;
  logic [DW-1:0] wval, rval;

  assign acc_ok = req && (size == 3'(NB));
  assign err    = req && (size != 3'(NB));

  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign wval[8*b +: 8]  = wdata[8*(NB-1-b) +: 8];
    assign rdata[8*b +: 8] = rval[8*(NB-1-b) +: 8];
  end

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    localparam int  CTL  = (t == 0) ? OFS_CD_CTL : OFS_PT_CTL;
    localparam bit  PER  = (t == 1);
    logic [DW-1:0] ivl_q, rem_q;
    logic          exp_q;
    logic          wr;

    assign wr = acc_ok && we && (addr == AW'(CTL));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ivl_q <= '0;
        rem_q <= '0;
        exp_q <= 1'b0;
      end else begin
        exp_q <= 1'b0;
        if (wr) begin
          ivl_q <= wval;
          rem_q <= wval;
        end else if (tick && rem_q != '0) begin
          if (rem_q == DW'(1)) begin
            exp_q <= 1'b1;
            if (PER) rem_q <= ivl_q;
            else begin
              rem_q <= '0;
              ivl_q <= '0;
            end
          end else begin
            rem_q <= rem_q - DW'(1);
          end
        end
      end
    end
  end

  assign cd_exp = g_tmr[0].exp_q;
  assign pt_exp = g_tmr[1].exp_q;

  always_comb begin
    rval = '0;
    if (acc_ok && !we) begin
      if (addr == AW'(OFS_CD_CTL))      rval = g_tmr[0].ivl_q;
      else if (addr == AW'(OFS_CD_VAL)) rval = g_tmr[0].rem_q;
      else if (addr == AW'(OFS_PT_CTL)) rval = g_tmr[1].ivl_q;
      else if (addr == AW'(OFS_PT_VAL)) rval = g_tmr[1].rem_q;
    end
  end
endmodule

module tick_timer_pair_chk #(
  parameter int DW         = 32,
  parameter int AW         = 6,
  parameter int OFS_CD_CTL = 32,
  parameter int OFS_PT_CTL = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          req,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [2:0]    size,
  input logic          cd_exp,
  input logic          pt_exp,
  input logic [DW-1:0] cd_ivl,
  input logic [DW-1:0] cd_rem,
  input logic [DW-1:0] pt_ivl,
  input logic [DW-1:0] pt_rem
);
  logic cd_wr, pt_wr, bad_wr;
  assign cd_wr  = req && we && size == 3'd4 && addr == AW'(OFS_CD_CTL);
  assign pt_wr  = req && we && size == 3'd4 && addr == AW'(OFS_PT_CTL);
  assign bad_wr = req && we && size != 3'd4;

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cd_exp |=> !cd_exp);
  a_r8_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cd_exp |-> (cd_ivl == '0 && cd_rem == '0));
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    pt_exp |-> (pt_rem == pt_ivl && pt_ivl != '0));
  a_r7_cd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cd_wr) |=> $stable(cd_rem));
  a_r7_pt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !pt_wr) |=> $stable(pt_rem));
  a_r10_cd_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cd_wr |=> !cd_exp);
  a_r10_pt_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pt_wr |=> !pt_exp);
  a_r3_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> $stable(pt_ivl));
endmodule

bind tick_timer_pair tick_timer_pair_chk #(
  .DW(DW), .AW(AW), .OFS_CD_CTL(OFS_CD_CTL), .OFS_PT_CTL(OFS_PT_CTL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .we(we), .addr(addr),
  .size(size), .cd_exp(cd_exp), .pt_exp(pt_exp),
  .cd_ivl(g_tmr[0].ivl_q), .cd_rem(g_tmr[0].rem_q),
  .pt_ivl(g_tmr[1].ivl_q), .pt_rem(g_tmr[1].rem_q)
);

// File: tb/tb_tick_timer_pair.sv
`timescale 1ns/1ps
module tb_tick_timer_pair;
  logic clk = 0, rst_n = 0, tick = 0, req = 0, we = 0;
  logic [5:0] addr = '0;
  logic [2:0] size = 3'd4;
  logic [31:0] wdata = '0, rdata;
  logic err, cd_exp, pt_exp;
  int checks = 0, errors = 0;
  int tick_mode = 0;
  int tick_phase = 0;
  int unsigned m_ivl [2];
  int unsigned m_rem [2];
  bit m_exp [2];

  always #2 clk = ~clk;

  tick_timer_pair dut (.clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .we(we),
    .addr(addr), .size(size), .wdata(wdata), .rdata(rdata), .err(err),
    .cd_exp(cd_exp), .pt_exp(pt_exp));

  function automatic logic [31:0] sw(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin m_ivl[i] = 0; m_rem[i] = 0; m_exp[i] = 0; end
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit wr;
        wr = req && we && size == 4 && addr == (i == 0 ? 32 : 40);
        m_exp[i] = 0;
        if (wr) begin m_ivl[i] = sw(wdata); m_rem[i] = sw(wdata); end
        else if (tick && m_rem[i] != 0) begin
          if (m_rem[i] == 1) begin
            m_exp[i] = 1;
            if (i == 1) m_rem[i] = m_ivl[i];
            else begin m_rem[i] = 0; m_ivl[i] = 0; end
          end else m_rem[i] = m_rem[i] - 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 one-shot expiry", 32'(cd_exp), 32'(m_exp[0]));
      chk("R9 periodic expiry", 32'(pt_exp), 32'(m_exp[1]));
    end
    tick_phase++;
    case (tick_mode)
      0: tick = 0;
      1: tick = 1;
      default: tick = (tick_phase % 2) == 0;
    endcase
  end

  function automatic logic [31:0] model_reg(input int a);
    case (a)
      32: return m_ivl[0];
      36: return m_rem[0];
      40: return m_ivl[1];
      44: return m_rem[1];
      default: return 0;
    endcase
  endfunction

  task automatic wr(input int a, input logic [31:0] v, input int sz);
    @(negedge clk);
    req = 1; we = 1; addr = 6'(a); size = 3'(sz); wdata = sw(v);
    #1;
    if (sz != 4) chk("R3 err on bad size", 32'(err), 1);
    @(negedge clk);
    req = 0; we = 0; size = 3'd4;
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    req = 1; we = 0; addr = 6'(a); size = 3'd4;
    #1;
    chk(tag, sw(rdata), model_reg(a));
    chk("R3 no err on word access", 32'(err), 0);
    @(negedge clk);
    req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    @(negedge clk);
    chk("R11 cd_exp after reset", 32'(cd_exp), 0);
    chk("R11 pt_exp after reset", 32'(pt_exp), 0);
    rd(32, "R11 cd ctl reset"); rd(36, "R11 cd val reset");
    rd(40, "R11 pt ctl reset"); rd(44, "R11 pt val reset");
    // R2 explicit lane check
    wr(40, 32'h0000_0102, 4);
    @(negedge clk); req = 1; we = 0; addr = 6'd40; #1;
    chk("R2 big-endian lanes", rdata, 32'h0201_0000);
    @(negedge clk); req = 0;
    wr(40, 0, 4);
    // R4 one-shot with continuous tick
    tick_mode = 1;
    wr(32, 5, 4);
    rd(32, "R4 cd ctl readback");
    rd(36, "R7 cd value counting");
    idle(8);
    rd(32, "R8 cd ctl cleared"); rd(36, "R8 cd val cleared");
    // R9 periodic, every other tick
    tick_mode = 2;
    wr(40, 3, 4);
    idle(5); rd(44, "R7 pt value");
    idle(20); rd(40, "R9 pt ctl kept");
    // R7 tick off: no movement
    tick_mode = 0;
    rd(44, "R7 pt hold a"); idle(6); rd(44, "R7 pt hold b");
    // R9 interval 1, tick every cycle
    tick_mode = 1;
    wr(40, 1, 4);
    idle(6);
    @(negedge clk); chk("R9 interval one pulses", 32'(pt_exp), 1);
    // R5 stop
    wr(40, 0, 4);
    idle(4);
    chk("R5 stopped no pulse", 32'(pt_exp), 0);
    rd(44, "R5 pt val stopped");
    // R6 rewrite mid-count
    wr(32, 20, 4); idle(3);
    wr(32, 4, 4); rd(36, "R6 restart count");
    idle(8);
    // R10 collision: write at the edge that would expire
    wr(32, 2, 4);
    wr(32, 7, 4);
    chk("R10 write wins no pulse", 32'(cd_exp), 0);
    rd(32, "R10 new interval");
    idle(12);
    // R3 bad size write ignored
    tick_mode = 0;
    wr(40, 9, 4);
    wr(40, 33, 2);
    rd(40, "R3 ctl unchanged by bad size");
    @(negedge clk); req = 1; we = 0; addr = 6'd40; size = 3'd1; #1;
    chk("R3 bad read data zero", rdata, 0);
    chk("R3 bad read err", 32'(err), 1);
    @(negedge clk); req = 0; size = 3'd4;
    // R1 value regs read-only, other offsets read zero
    wr(44, 77, 4);
    rd(44, "R1 value write ignored");
    wr(8, 55, 4);
    rd(8, "R1 unused offset zero");
    rd(40, "R1 ctl unaffected");
    wr(40, 0, 4);
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule